// File: doc/BRIEF.md
# Dataflow Module Firing Sequencer

This control wrapper sits around one simulated module in a cycle-accurate model that is spread over many channels. It decides when the wrapped module may simulate its next model cycle, based on the state of its N input channels and M output channels. When the firing rule is met, it issues a one-cycle start pulse. It then waits for as many clock cycles as the module needs. It records each output channel write and, once every output has been written once, pops exactly one token from every input channel. The count of completed firings is the module's local model-cycle number.

Input channels follow valid/ready rules. `in_valid[i]` means channel i holds a head token. A token counts whether it carries data or a no-message marker. `in_ready[i]` is the pop strobe, and a token leaves only when both are high. The sequencer applies back-pressure by holding `in_ready` low until a firing is complete. The channel must then keep `in_valid` high. Output writes are a valid-only strobe, `out_wr[j]`, which the channel always accepts. Three modes set the firing permit. In run mode it fires freely. In rebalance mode it fires only to correct heavy inputs or light outputs. In pause mode it fires once per step command, and switching back to run mode resumes.

Top module: `dfmod_fire_seq`

## Requirements
- R1: While rst_n is low and after it is released, fire_start, busy and in_ready are low and model_cycle is zero.
- R2: In run mode (mode = 0), fire_start rises one cycle after every in_valid bit is high in the idle state. If any in_valid bit is low, no firing starts. The payload of a token is never examined.
- R3: in_ready is all ones for exactly one cycle, the cycle after the last outstanding output write is seen, and it is never high before that.
- R4: Each output channel must be written exactly once per firing, with the j-th bit of out_wr marking channel j. Writes seen while the block is not busy are ignored and do not count toward the next firing.
- R5: In rebalance mode (mode = 1), a firing starts only if every in_valid bit is high and at least one in_heavy bit or one out_light bit is high.
- R6: rebal_idle is high when the mode is rebalance, the block is idle, and the rebalance firing rule of R5 does not hold. It is low otherwise.
- R7: In pause mode (mode = 2 or 3), no firing starts without a step pulse. One step pulse allows exactly one firing, taken as soon as all inputs are valid.
- R8: model_cycle increases by one in the cycle after each pop and holds at all other times.
- R9: fire_start is a single-cycle pulse per firing, and busy stays high from the start pulse through the pop cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode | input | 2 | 0 run, 1 rebalance, 2/3 pause |
| step | input | 1 | Step command pulse, meaningful in pause mode |
| in_valid | input | N | Input channel i holds a head token |
| in_heavy | input | N | Input channel i is above its balance level |
| in_ready | output | N | Pop strobe, one token per channel |
| out_light | input | M | Output channel j is below its balance level |
| out_wr | input | M | Wrapped module writes output channel j this cycle |
| fire_start | output | 1 | Start pulse for one model cycle of the wrapped module |
| busy | output | 1 | A firing is in progress |
| rebal_idle | output | 1 | Rebalance mode with nothing to correct |
| model_cycle | output | CW | Completed firings count |

## Verification
A qualifying input pattern, applied before an edge in the idle state, shows as fire_start after that edge. The bench drives on the falling edge and samples on the next falling edge. The pop is due one edge after the final output write has been sampled, and the model-cycle count moves one edge after that. The bench therefore checks in_ready and model_cycle at those two falling edges, clearing in_valid before the second one so that no new firing is pending. rebal_idle is combinational on the idle state, so it is checked in the same half-cycle as the fire decision.

// File: rtl/dfseq_pkg.sv
package dfseq_pkg;
  localparam logic [1:0] MODE_RUN   = 2'd0;
  localparam logic [1:0] MODE_REBAL = 2'd1;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_FIRE = 2'd1,
    ST_WAIT = 2'd2,
    ST_POP  = 2'd3
  } seq_state_e;
endpackage

// File: rtl/dfseq_fire_gate.sv
module dfseq_fire_gate #(
  parameter int N = 3,
  parameter int M = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [1:0]   mode,
  input  logic         step,
  input  logic [N-1:0] in_valid,
  input  logic [N-1:0] in_heavy,
  input  logic [M-1:0] out_light,
  input  logic         at_idle,
  output logic         go,
  output logic         rebal_idle
);
  import dfseq_pkg::*;

  logic all_valid, need_fix, is_pause, credit_q, permit;

  assign all_valid = &in_valid;
  assign need_fix  = (|in_heavy) | (|out_light);
  assign is_pause  = mode[1];

  always_comb begin
    if (mode == MODE_RUN)        permit = 1'b1;
    else if (mode == MODE_REBAL) permit = need_fix;
    else                         permit = credit_q;
  end

  assign go         = at_idle & all_valid & permit;
  assign rebal_idle = (mode == MODE_REBAL) & at_idle & ~(all_valid & need_fix);

  always_ff @(posedge clk) begin
    if (!rst_n)         credit_q <= 1'b0;
    else if (!is_pause) credit_q <= 1'b0;
    else if (go)        credit_q <= 1'b0;
    else if (step)      credit_q <= 1'b1;
  end

  // R5
  rebal_rule_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (go && mode == MODE_REBAL) |-> (need_fix && all_valid));
endmodule

// File: rtl/dfseq_write_tracker.sv
module dfseq_write_tracker #(
  parameter int M = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear,
  input  logic         open,
  input  logic [M-1:0] out_wr,
  output logic [M-1:0] wr_mask,
  output logic         all_done
);
  logic [M-1:0] seen;

  assign seen     = wr_mask | out_wr;
  assign all_done = open & (&seen);

  always_ff @(posedge clk) begin
    if (!rst_n)     wr_mask <= '0;
    else if (clear) wr_mask <= '0;
    else if (open)  wr_mask <= seen;
  end

  // R4
  no_double_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    open |-> ((out_wr & wr_mask) == '0));
endmodule

// File: rtl/dfseq_cycle_ctr.sv
module dfseq_cycle_ctr #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          inc,
  output logic [CW-1:0] count
);
  always_ff @(posedge clk) begin
    if (!rst_n)   count <= '0;
    else if (inc) count <= count + 1'b1;
  end

  // R8
  ctr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inc |=> (count == $past(count) + 1'b1));
  // R8
  ctr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !inc |=> $stable(count));
endmodule

// File: rtl/dfmod_fire_seq.sv
module dfmod_fire_seq #(
  parameter int N  = 3,
  parameter int M  = 2,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    mode,
  input  logic          step,
  input  logic [N-1:0]  in_valid,
  input  logic [N-1:0]  in_heavy,
  output logic [N-1:0]  in_ready,
  input  logic [M-1:0]  out_light,
  input  logic [M-1:0]  out_wr,
  output logic          fire_start,
  output logic          busy,
  output logic          rebal_idle,
  output logic [CW-1:0] model_cycle
);
  import dfseq_pkg::*;

  seq_state_e   state_q, state_d;
  logic         go, all_done, open;
  logic [M-1:0] wr_mask;

  dfseq_fire_gate #(.N(N), .M(M)) u_gate (
    .clk(clk), .rst_n(rst_n), .mode(mode), .step(step),
    .in_valid(in_valid), .in_heavy(in_heavy), .out_light(out_light),
    .at_idle(state_q == ST_IDLE), .go(go), .rebal_idle(rebal_idle)
  );

  assign open = (state_q == ST_FIRE) | (state_q == ST_WAIT);

  dfseq_write_tracker #(.M(M)) u_track (
    .clk(clk), .rst_n(rst_n), .clear(go), .open(open),
    .out_wr(out_wr), .wr_mask(wr_mask), .all_done(all_done)
  );

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE: if (go) state_d = ST_FIRE;
      ST_FIRE: state_d = all_done ? ST_POP : ST_WAIT;
      ST_WAIT: if (all_done) state_d = ST_POP;
      ST_POP:  state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign fire_start = (state_q == ST_FIRE);
  assign busy       = (state_q != ST_IDLE);

  for (genvar i = 0; i < N; i++) begin : g_pop
    assign in_ready[i] = (state_q == ST_POP);
  end

  dfseq_cycle_ctr #(.CW(CW)) u_ctr (
    .clk(clk), .rst_n(rst_n), .inc(state_q == ST_POP), .count(model_cycle)
  );

  // R3
  pop_after_writes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|in_ready) |-> (&wr_mask));
  // R2
  fire_needs_tokens_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fire_start) |-> $past(&in_valid));
  // R9
  start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire_start |=> !fire_start);
endmodule

// File: tb/dfmod_fire_seq_bench.sv
module dfmod_fire_seq_bench;
  localparam int N = 3;
  localparam int M = 2;
  localparam int CW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] mode = 2'd0;
  logic step = 1'b0;
  logic [N-1:0] in_valid = '0, in_heavy = '0, in_ready;
  logic [M-1:0] out_light = '0, out_wr = '0;
  logic fire_start, busy, rebal_idle;
  logic [CW-1:0] model_cycle;

  int total = 0, bad = 0, exp_cnt = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  dfmod_fire_seq #(.N(N), .M(M), .CW(CW)) u_dfmod_fire_seq (
    .clk(clk), .rst_n(rst_n), .mode(mode), .step(step),
    .in_valid(in_valid), .in_heavy(in_heavy), .in_ready(in_ready),
    .out_light(out_light), .out_wr(out_wr), .fire_start(fire_start),
    .busy(busy), .rebal_idle(rebal_idle), .model_cycle(model_cycle)
  );

  // {mode, valid, heavy, light, expect fire, expect rebal_idle}
  localparam logic [11:0] VEC [0:6] = '{
    {2'd0, 3'b111, 3'b000, 2'b00, 1'b1, 1'b0},
    {2'd0, 3'b110, 3'b000, 2'b00, 1'b0, 1'b0},
    {2'd1, 3'b111, 3'b000, 2'b00, 1'b0, 1'b1},
    {2'd1, 3'b111, 3'b010, 2'b00, 1'b1, 1'b0},
    {2'd1, 3'b111, 3'b000, 2'b01, 1'b1, 1'b0},
    {2'd1, 3'b011, 3'b100, 2'b00, 1'b0, 1'b1},
    {2'd2, 3'b111, 3'b000, 2'b00, 1'b0, 1'b0}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk);
    @(negedge clk);
  endtask

  // Ends a firing that has just started: all writes, pop, count.
  task automatic finish_fire;
    out_wr = '1;
    tick();
    out_wr = '0;
    in_valid = '0;
    chk(in_ready == '1, "R3 pop", int'(in_ready), 7);
    chk(busy == 1'b1, "R9 busy at pop", int'(busy), 1);
    tick();
    exp_cnt++;
    chk(model_cycle == CW'(exp_cnt), "R8 count", int'(model_cycle), exp_cnt);
    chk(in_ready == '0, "R3 single pop", int'(in_ready), 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog act=0 exp=1");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    tick();
    // R1 reset state
    chk(fire_start == 1'b0 && busy == 1'b0, "R1 ctl", int'({fire_start, busy}), 0);
    chk(in_ready == '0 && model_cycle == '0, "R1 pop/count", int'(model_cycle), 0);
    rst_n = 1'b1;
    tick();
    chk(busy == 1'b0 && model_cycle == '0, "R1 after release", int'(busy), 0);

    for (int i = 0; i < 7; i++) begin
      mode = VEC[i][11:10];
      in_valid = VEC[i][9:7];
      in_heavy = VEC[i][6:4];
      out_light = VEC[i][3:2];
      tick();
      chk(fire_start == VEC[i][1], "R2/R5/R7 fire", int'(fire_start), int'(VEC[i][1]));
      chk(rebal_idle == VEC[i][0], "R6 rebal_idle", int'(rebal_idle), int'(VEC[i][0]));
      if (VEC[i][1]) finish_fire();
      else in_valid = '0;
      in_heavy = '0;
      out_light = '0;
      tick();
    end

    // R7: single step in pause mode
    mode = 2'd2;
    step = 1'b1;
    tick();
    step = 1'b0;
    tick();
    chk(busy == 1'b0, "R7 step alone no fire", int'(busy), 0);
    in_valid = '1;
    tick();
    chk(fire_start == 1'b1, "R7 step fire", int'(fire_start), 1);
    finish_fire();
    in_valid = '1;
    tick();
    tick();
    chk(busy == 1'b0, "R7 one firing per step", int'(busy), 0);
    in_valid = '0;

    // R4: stray writes while idle, then split writes
    mode = 2'd0;
    out_wr = 2'b11;
    tick();
    out_wr = '0;
    in_valid = '1;
    tick();
    chk(fire_start == 1'b1, "R2 fire", int'(fire_start), 1);
    out_wr = 2'b01;
    tick();
    out_wr = '0;
    chk(in_ready == '0, "R4 stray writes ignored", int'(in_ready), 0);
    chk(fire_start == 1'b0, "R9 pulse width", int'(fire_start), 0);
    tick();
    tick();
    chk(in_ready == '0 && busy == 1'b1, "R3 no early pop", int'(in_ready), 0);
    out_wr = 2'b10;
    tick();
    out_wr = '0;
    in_valid = '0;
    chk(in_ready == '1, "R3 pop after last write", int'(in_ready), 7);
    tick();
    exp_cnt++;
    chk(model_cycle == CW'(exp_cnt), "R8 count", int'(model_cycle), exp_cnt);
    tick();
    chk(model_cycle == CW'(exp_cnt), "R8 hold", int'(model_cycle), exp_cnt);

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule